// File: doc/BRIEF.md
# Burst Address Sequencer with Linear and Interleaved Order

This block produces the array address for a short burst access. When an access starts, it takes in a base address. The upper bits are kept fixed for the whole burst. The low bits seed a small wraparound beat counter. On each later clock edge where the active-low advance input is asserted, the block moves to the next address in the burst. The order of those addresses is either linear (the low bits count up from the start and wrap) or interleaved (the low bits are the start XOR the beat number). Which order applies is fixed by an order-select input that is sampled when the burst is loaded.

A small state machine controls the sequencing. It has two states. SEQ_IDLE is the state after reset, before any access has been loaded. SEQ_BURST is the state while a burst is active. Three transitions are named. START goes from SEQ_IDLE to SEQ_BURST on a load strobe. RESTART loops from SEQ_BURST to SEQ_BURST on a load strobe and reloads from a new base. STEP/HOLD loops from SEQ_BURST to SEQ_BURST without a load; it steps when advance is low and holds when advance is high. The output address is formed from registered state only, so it is valid in the cycle after the edge that changed it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `cur_addr` is all zeros. Until the first load, `adv_n` has no effect and `cur_addr` stays zero.
- R2: A rising edge with `addr_ld`=1 makes `cur_addr` equal to the `base_addr` value sampled at that edge, starting in the next cycle.
- R3: At an edge where `addr_ld`=1, `adv_n` is ignored. The cycle after a load always shows beat 0, which is the base address itself.
- R4: During a burst, an edge with `addr_ld`=0 and `adv_n`=1 leaves `cur_addr` unchanged (suspend).
- R5: The bits of `cur_addr` above the two low bits keep their loaded value until the next load.
- R6: With linear order (`order_il`=0 at load), beat n has low bits equal to (start + n) mod 4.
- R7: With interleaved order (`order_il`=1 at load), beat n has low bits equal to start XOR n.
- R8: The beat number rises by one on each edge with `addr_ld`=0 and `adv_n`=0. After the fourth such advance, the address is back at the start address.
- R9: A load during a burst restarts the sequence at beat 0 of the new base address, whatever the current beat.
- R10: The order is captured at load. A change of `order_il` during a burst does not change the sequence until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load strobe, active high; starts or restarts a burst |
| adv_n | input | 1 | Advance, active low; steps the burst by one beat |
| order_il | input | 1 | Order select sampled at load: 1 interleaved, 0 linear |
| base_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Current array address |

## Verification
The bench sweeps all four start offsets in both orders. It steps each burst past the wrap point and puts suspends between beats. A design that mixes up the two orders would give a wrong address at beat 1 or beat 3 for some start offsets. A design with a bad wrap would not return to the start after the fourth advance. Further directed cases apply load and advance in the same edge (a design that honours the advance would skip beat 0), advance before any load (a design that counts in the idle state would leave zero), a restart partway through a burst (a design that keeps the old beat count would resume at that beat), and toggling the order select mid-burst (a design that reads the order live would change sequence partway through).

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_t;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_t;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic       adv_n,
    output seq_state_t state,
    output logic       beat_clr,
    output logic       beat_inc
);

    seq_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        beat_clr  = 1'b0;
        beat_inc  = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (ld) begin          // START
                    state_nxt = SEQ_BURST;
                    beat_clr  = 1'b1;
                end
            end
            SEQ_BURST: begin
                if (ld) begin          // RESTART
                    beat_clr = 1'b1;
                end else begin         // STEP / HOLD
                    beat_inc = !adv_n;
                end
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // R3
    ld_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !beat_inc);

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] beat
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   beat <= '0;
        else if (clr) beat <= '0;
        else if (inc) beat <= beat + ONE;
    end

    // R8
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> beat == $past(beat) + ONE);

    // R9
    beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> beat == '0);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  logic             interleave,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_xor
            assign xor_low[gi] = start[gi] ^ beat[gi];
        end
    endgenerate

    assign lin_low = start + beat;

    always_comb begin
        low = interleave ? xor_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int UP_W = ADDR_W - CNT_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state;
    logic             beat_clr;
    logic             beat_inc;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] start_q;
    logic [UP_W-1:0]  upper_q;
    order_t           order_q;
    logic [CNT_W-1:0] low;

    burst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (addr_ld),
        .adv_n    (adv_n),
        .state    (state),
        .beat_clr (beat_clr),
        .beat_inc (beat_inc)
    );

    burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (beat_clr),
        .inc   (beat_inc),
        .beat  (beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            upper_q <= '0;
            order_q <= ORD_LINEAR;
        end else if (beat_clr) begin
            start_q <= base_addr[CNT_W-1:0];
            upper_q <= base_addr[ADDR_W-1:CNT_W];
            order_q <= order_t'(order_il);
        end
    end

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .start      (start_q),
        .beat       (beat),
        .interleave (order_q == ORD_INTERLEAVED),
        .low        (low)
    );

    assign cur_addr = {upper_q, low};

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE) |-> cur_addr == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> cur_addr == $past(base_addr));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_BURST && !addr_ld && adv_n) |=> $stable(cur_addr));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ld |=> $stable(cur_addr[ADDR_W-1:CNT_W]));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_BURST && !addr_ld && !adv_n && order_q == ORD_LINEAR)
        |=> cur_addr[CNT_W-1:0] == $past(cur_addr[CNT_W-1:0]) + ONE);

    // R10
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ld |=> $stable(order_q));

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_ld = 1'b0;
    logic              adv_n = 1'b1;
    logic              order_il = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] cur_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_ld   (addr_ld),
        .adv_n     (adv_n),
        .order_il  (order_il),
        .base_addr (base_addr),
        .cur_addr  (cur_addr)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] got,
                         input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: cur_addr=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic advn,
                       input logic [ADDR_W-1:0] base, input logic il);
        addr_ld   = ld;
        adv_n     = advn;
        base_addr = base;
        order_il  = il;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [ADDR_W-1:0] expect_addr(
        input logic [ADDR_W-1:0] base, input int n, input bit il);
        logic [1:0] s;
        logic [1:0] b;
        s = base[1:0];
        b = 2'(n % 4);
        return {base[ADDR_W-1:2], il ? (s ^ b) : 2'(s + b)};
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cur_addr=%h expected=completion", cur_addr);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] b;
        int n;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", cur_addr, '0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 16'h1234, 1'b1);
        cyc(1'b0, 1'b0, 16'h1234, 1'b1);
        check("R1 advance before load", cur_addr, '0);

        // sweep both orders and all start offsets
        for (int il = 0; il < 2; il++) begin
            for (int s = 0; s < 4; s++) begin
                b = 16'(16'hA5C0 + il * 16'h0110 + s);
                cyc(1'b1, 1'b0, b, il[0]);   // R3: advance ignored on load
                check("R2/R3 load beat0", cur_addr, b);
                n = 0;
                for (int k = 0; k < 6; k++) begin
                    cyc(1'b0, 1'b0, 16'hFFFF, ~il[0]);
                    n++;
                    check(il ? "R7/R8/R10 interleaved" : "R6/R8/R10 linear",
                          cur_addr, expect_addr(b, n, il[0]));
                    if (k == 1) begin
                        cyc(1'b0, 1'b1, 16'h0000, il[0]);
                        check("R4/R5 suspend", cur_addr, expect_addr(b, n, il[0]));
                    end
                    if (n == 4)
                        check("R8 wrap to start", cur_addr, b);
                end
            end
        end

        // R9: restart mid-burst
        cyc(1'b1, 1'b1, 16'h3C02, 1'b0);
        cyc(1'b0, 1'b0, 16'h0, 1'b0);
        cyc(1'b0, 1'b0, 16'h0, 1'b0);
        check("R6 linear two steps", cur_addr, 16'h3C00);
        cyc(1'b1, 1'b1, 16'h7E13, 1'b1);
        check("R9 restart beat0", cur_addr, 16'h7E13);
        cyc(1'b0, 1'b0, 16'h0, 1'b0);
        check("R9 restart interleaved beat1", cur_addr, 16'h7E12);
        cyc(1'b0, 1'b1, 16'h0, 1'b0);
        cyc(1'b0, 1'b1, 16'h0, 1'b1);
        check("R4 long suspend", cur_addr, 16'h7E12);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule